// File: doc/BRIEF.md
# SATA Out-of-Band Transmit Sequencer

This block sits between a SATA link-layer controller and the out-of-band control ports of a serial transceiver. The link layer asks for either a reset/init signalling sequence (COMRESET on the host side, COMINIT on the device side) or a wake sequence. The block answers with a single-cycle command pulse on the matching transceiver input. Before and after each sequence it holds the transmitter in electrical idle, and it lowers that control only while a sequence is in flight.

The transceiver's own finish strobe cannot be trusted on its own. It may fail to arrive, or it may arrive late and belong to the sequence sent before. For this reason the block counts cycles from its command pulse. It accepts a finish strobe only once a short guard window has passed. If no valid strobe arrives before a limit, it completes the sequence itself. That limit depends on the sequence type and on the selected SATA generation, because the user clock doubles with each generation. A status bit records which of the two sources ended the last sequence.

Top module: `sata_oob_tx_seq`

## Requirements
- R1: After a synchronous reset, busy and done are 0, both command pulses are 0, the timeout status bit is 0 and the electrical-idle control is 1.
- R2: When req_init is high while busy is low, the cycle after the accepting edge shows a one-cycle pulse on phy_cominit, and busy is high from that same cycle.
- R3: When req_wake alone is high while busy is low, the cycle after the accepting edge shows a one-cycle pulse on phy_comwake and no pulse on phy_cominit.
- R4: If req_init and req_wake are high in the same accepting cycle, only phy_cominit pulses.
- R5: Requests that arrive while busy is high produce no command pulse and do not restart the running sequence's timeout.
- R6: phy_tx_elec_idle is 1 in exactly the cycles where busy is 0.
- R7: Number the command pulse cycle as 0. A phy_com_finish strobe in cycle k, with k at least GUARD_CYC (default 8), ends the sequence: done is high in cycle k+1 and done_by_timeout reads 0.
- R8: A phy_com_finish strobe in any cycle below GUARD_CYC is ignored. It neither ends the sequence nor shortens it.
- R9: With no honoured strobe, done rises in cycle L and done_by_timeout reads 1. For the init sequence L is 432, 864 and 1728 cycles when gen_sel is 0, 1 and 2. For the wake sequence L is 192, 384 and 768 cycles for the same settings. gen_sel value 3 behaves like 2.
- R10: done is high for exactly one cycle, and busy is 0 in that cycle.
- R11: gen_sel is sampled only at the accepting edge. Changing it during a sequence does not change that sequence's limit.
- R12: If an honoured strobe falls in cycle L-1, which is the same cycle the timeout expires, the completion counts as acknowledged (done_by_timeout 0) and done still rises in cycle L.
- R13: done_by_timeout keeps its value from one completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver user clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_sel | input | 2 | Active generation: 0 Gen1, 1 Gen2, 2 or 3 Gen3 |
| req_init | input | 1 | Request an init/reset sequence |
| req_wake | input | 1 | Request a wake sequence |
| phy_com_finish | input | 1 | Transceiver finish strobe |
| phy_cominit | output | 1 | One-cycle init command to the transceiver |
| phy_comwake | output | 1 | One-cycle wake command to the transceiver |
| phy_tx_elec_idle | output | 1 | Transmit electrical-idle control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| done_by_timeout | output | 1 | Last completion came from the timeout |

## Verification
The two completion sources can fall in the same cycle: a valid transceiver strobe and expiry of the timeout. The bench provokes this by placing the strobe in cycle L-1 after the pulse. It then expects done in cycle L with the acknowledge flag winning. A second case makes a fresh request coincide with a running sequence, or both request inputs coincide. There the bench judges the pulse outputs and the length of the sequence that follows.

// File: rtl/sata_oob_tx_seq.sv
module sata_oob_tx_seq #(
  parameter int INIT_GEN1_CYC = 432,
  parameter int WAKE_GEN1_CYC = 192,
  parameter int GUARD_CYC     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] gen_sel,
  input  logic       req_init,
  input  logic       req_wake,
  input  logic       phy_com_finish,
  output logic       phy_cominit,
  output logic       phy_comwake,
  output logic       phy_tx_elec_idle,
  output logic       busy,
  output logic       done,
  output logic       done_by_timeout
);
  localparam int MAXB = (INIT_GEN1_CYC > WAKE_GEN1_CYC) ? INIT_GEN1_CYC : WAKE_GEN1_CYC;
  localparam int CW   = $clog2(MAXB * 4 + 1);

  logic          busy_q, done_q, byto_q, ci_q, cw_q, idle_q;
  logic [CW-1:0] cnt_q, lim_q;

  wire           accept  = !busy_q && (req_init || req_wake);
  wire  [CW-1:0] base    = req_init ? CW'(INIT_GEN1_CYC) : CW'(WAKE_GEN1_CYC);
  wire  [1:0]    shift   = (gen_sel == 2'd0) ? 2'd0 : (gen_sel == 2'd1) ? 2'd1 : 2'd2;
  wire  [CW-1:0] lim_nxt = base << shift;
  wire           ack     = busy_q && phy_com_finish && (cnt_q >= CW'(GUARD_CYC));
  wire           expire  = busy_q && (cnt_q == lim_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      byto_q <= 1'b0;
      ci_q   <= 1'b0;
      cw_q   <= 1'b0;
      idle_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      ci_q   <= accept && req_init;
      cw_q   <= accept && !req_init;
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        idle_q <= 1'b0;
        cnt_q  <= '0;
        lim_q  <= lim_nxt;
      end else if (ack || expire) begin
        busy_q <= 1'b0;
        idle_q <= 1'b1;
        done_q <= 1'b1;
        byto_q <= !ack;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign phy_cominit      = ci_q;
  assign phy_comwake      = cw_q;
  assign phy_tx_elec_idle = idle_q;
  assign busy             = busy_q;
  assign done             = done_q;
  assign done_by_timeout  = byto_q;

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (ci_q ^ cw_q));
  assert_init_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    ci_q |=> !ci_q);
  assert_wake_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    cw_q |=> !cw_q);
  assert_init_priority_R4: assert property (@(posedge clk) disable iff (rst)
    cw_q |-> !$past(req_init));
  assert_no_pulse_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ci_q && !cw_q) |=> (!ci_q && !cw_q) || !$past(busy_q));
  assert_idle_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q != idle_q);
  assert_ack_source_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !byto_q) |-> $past(phy_com_finish));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q ##1 !done_q);
endmodule

// File: tb/sata_oob_tx_seq_tb_top.sv
module sata_oob_tx_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] gen_sel = 2'd0;
  logic req_init = 1'b0, req_wake = 1'b0, phy_com_finish = 1'b0;
  logic phy_cominit, phy_comwake, phy_tx_elec_idle, busy, done, done_by_timeout;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  sata_oob_tx_seq dut_i (
    .clk(clk), .rst(rst), .gen_sel(gen_sel), .req_init(req_init), .req_wake(req_wake),
    .phy_com_finish(phy_com_finish), .phy_cominit(phy_cominit), .phy_comwake(phy_comwake),
    .phy_tx_elec_idle(phy_tx_elec_idle), .busy(busy), .done(done),
    .done_by_timeout(done_by_timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // leaves the bench inside pulse cycle 0
  task automatic start(input bit i, input bit w, input logic [1:0] g);
    gen_sel = g; req_init = i; req_wake = w;
    @(negedge clk);
    req_init = 1'b0; req_wake = 1'b0;
    chk("R2 cominit", phy_cominit, i);
    chk("R3 comwake", phy_comwake, !i && w);
    chk("R2 busy", busy, 1);
    chk("R6 elec idle low", phy_tx_elec_idle, 0);
  endtask

  task automatic wait_done(output int c);
    c = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); c++;
      if (done) break;
    end
  endtask

  task automatic check_done(input string req, input int byto);
    chk({req, " done"}, done, 1);
    chk({req, " busy low"}, busy, 0);
    chk("R6 elec idle high", phy_tx_elec_idle, 1);
    chk({req, " by_timeout"}, done_by_timeout, byto);
    @(negedge clk);
    chk("R10 done single", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 pulses", phy_cominit | phy_comwake, 0);
    chk("R1 by_timeout", done_by_timeout, 0);
    chk("R1 elec idle", phy_tx_elec_idle, 1);
  endtask

  task automatic t_timeout(input bit i, input logic [1:0] g, input int lim);
    int c;
    start(i, !i, g);
    wait_done(c);
    chk("R9 timeout length", c, lim);
    check_done("R9", 1);
  endtask

  task automatic t_ack(input int k);
    start(1, 0, 0);
    repeat (k) @(negedge clk);
    phy_com_finish = 1'b1;
    @(negedge clk);
    phy_com_finish = 1'b0;
    chk("R7 done after ack", done, 1);
    check_done("R7", 0);
  endtask

  task automatic t_stale();
    int c;
    start(0, 1, 0);
    repeat (3) @(negedge clk);
    phy_com_finish = 1'b1;
    @(negedge clk); phy_com_finish = 1'b0;
    repeat (3) @(negedge clk);
    phy_com_finish = 1'b1;          // cycle 7, still inside guard
    @(negedge clk); phy_com_finish = 1'b0;
    chk("R8 stale ignored", done, 0);
    chk("R8 still busy", busy, 1);
    wait_done(c);
    chk("R8 full timeout", c + 8, 192);
    check_done("R8", 1);
  endtask

  task automatic t_same_cycle();
    start(1, 0, 0);
    repeat (431) @(negedge clk);
    phy_com_finish = 1'b1;
    @(negedge clk); phy_com_finish = 1'b0;
    check_done("R12", 0);
  endtask

  task automatic t_both();
    int c;
    start(1, 1, 0);
    chk("R4 no comwake", phy_comwake, 0);
    wait_done(c);
    chk("R4 init length", c, 432);
    check_done("R4", 1);
  endtask

  task automatic t_busy_ignored();
    int c;
    start(1, 0, 0);
    @(negedge clk);
    gen_sel = 2'd2;
    req_wake = 1'b1; req_init = 1'b1;
    @(negedge clk);
    req_wake = 1'b0; req_init = 1'b0;
    chk("R5 no pulse while busy", phy_cominit | phy_comwake, 0);
    wait_done(c);
    chk("R5 R11 limit unchanged", c + 2, 432);
    check_done("R11", 1);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk("R13 status held", done_by_timeout, 1);
    t_ack(8);
    repeat (3) @(negedge clk);
    chk("R13 status held after ack", done_by_timeout, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timeout(1, 0, 432);
    t_timeout(1, 1, 864);
    t_timeout(1, 2, 1728);
    t_timeout(0, 0, 192);
    t_timeout(0, 1, 384);
    t_timeout(0, 3, 768);
    t_ack(8);
    t_ack(100);
    t_stale();
    t_same_cycle();
    t_both();
    t_busy_ignored();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule